// File: doc/BRIEF.md
# Descriptor Ring Source-Side Copy Engine

This block is the sending half of a copy engine. Software places 64-bit descriptors in a small local descriptor memory that the block holds. It then moves a write index forward through a register port. The engine walks its own read index toward that write index. For each descriptor it fetches the buffer address, byte count and flags, and it offers the fragment on a valid/ready request port. A downstream bus master does the actual data movement.

Fragments whose gather flag is set are chained with the following descriptor into one transfer, and the request port marks the first and last fragment. A programmable length cap drops any oversized descriptor and records an error. A write-index update that would run past the completion index is refused and flagged. Software can request a halt. The engine stops only at a transfer boundary and reports when it has stopped.

Top module: `ring_copy_src`

## Requirements
- R1: A descriptor is 64 bits: buffer address in bits 31:0, byte count in bits 47:32, flags in bits 63:48. The request port carries the address, the byte count, flags bit 1 as the swap request, and flags bits 15:3 unchanged as a 13-bit tag.
- R2: Flags bit 0 set means the fragment continues into the next descriptor. The request port marks a fragment last when its bit 0 is clear, and first when the previously consumed descriptor had bit 0 clear (or none has been consumed since reset).
- R3: Register 1 holds log2 of the ring entry count (reset: full memory depth), and indices wrap with mask (entries-1). Register 0 is a base slot, and ring entry i lives in memory slot (base + i) modulo the memory depth.
- R4: A descriptor is fetched only when the read index differs from the write index (register 2). Each consumed descriptor advances the read index by one modulo ring size, and register 3 reads it back.
- R5: Once the request valid is raised, it stays high and its fields stay unchanged until ready is seen.
- R6: Register 6 bits 15:0 hold the maximum byte count (reset 0xFFFF). A descriptor whose count exceeds it is consumed without being offered and sets error bit 0 of register 7. A count equal to the limit is offered normally.
- R7: A write to register 2 is refused, and error bit 1 of register 7 is set, when the forward distance from the old to the new write index, (new-old)&mask, exceeds the free space (completion-old-1)&mask. The completion index is in register 4.
- R8: Writing register 5 bit 0 as 1 requests a halt. Register 5 bit 3 reads 1 once the engine has stopped, and while it is stopped no descriptor is fetched or offered. Clearing bit 0 resumes.
- R9: A halt requested mid-chain takes effect only after the last fragment of the current gather chain has been consumed.
- R10: copy_done pulses for exactly one cycle when a descriptor with flags bit 0 clear is consumed, whether it was offered or dropped for length.
- R11: After reset, the read and write indices are 0, valid is low, halted is 0 and both error bits are 0. Writing 1 to a bit of register 7 clears that error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| desc_we | input | 1 | Descriptor memory write strobe |
| desc_waddr | input | $clog2(DESC_DEPTH) | Descriptor memory slot |
| desc_wdata | input | 64 | Descriptor to store |
| req_valid | output | 1 | Fragment request valid |
| req_ready | input | 1 | Fragment request accepted |
| req_addr | output | 32 | Fragment buffer address |
| req_len | output | 16 | Fragment byte count |
| req_swap | output | 1 | Byte-swap request |
| req_tag | output | 13 | Pass-through transfer tag |
| req_first | output | 1 | First fragment of a transfer |
| req_last | output | 1 | Last fragment of a transfer |
| copy_done | output | 1 | One-cycle transfer completion pulse |

## Verification
A read index that steps wrongly shows up at once as a request with the wrong address or tag, and as a wrong register 3 value within three cycles of the write-index update. A stale chain flag shows as a wrong first/last marking on the next fragment, or as a halt that arrives one fragment early. Errors in the overflow or length comparisons show in register 7 in the cycle after the offending write or fetch. They also show as a missing or extra fragment on the request port.

// File: rtl/rcs_pkg.sv
// Shared types for the ring copy source: descriptor layout, engine states
// and register slot numbers. Assumes fixed 64-bit descriptors.
package rcs_pkg;
    localparam int BUF_AW   = 32;
    localparam int CNT_W    = 16;
    localparam int TAG_LSB  = 3;
    localparam int TAG_W    = 16 - TAG_LSB;

    typedef struct packed {
        logic [15:0]       flags;
        logic [CNT_W-1:0]  nbytes;
        logic [BUF_AW-1:0] addr;
    } desc_t;

    typedef enum logic [1:0] {ENG_IDLE, ENG_LOAD, ENG_SEND, ENG_HALT} eng_state_e;

    localparam logic [3:0] REG_BASE = 4'd0;
    localparam logic [3:0] REG_SIZE = 4'd1;
    localparam logic [3:0] REG_WR   = 4'd2;
    localparam logic [3:0] REG_RD   = 4'd3;
    localparam logic [3:0] REG_CMPL = 4'd4;
    localparam logic [3:0] REG_CMD  = 4'd5;
    localparam logic [3:0] REG_MAX  = 4'd6;
    localparam logic [3:0] REG_ERR  = 4'd7;
endpackage

// File: rtl/rcs_desc_ram.sv
// Descriptor storage: one write port for software, one registered read port
// for the engine. Assumes read data is consumed one cycle after re.
module rcs_desc_ram
    import rcs_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  desc_t         wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output desc_t         rdata
);
    desc_t mem [DEPTH];

    // Store software writes and register the engine's read.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/rcs_ctrl_regs.sv
// Software-visible registers: ring base and size, write and completion
// indices with overflow guard, halt command, length cap and sticky errors.
// Assumes base and size are changed only while the ring is empty.
module rcs_ctrl_regs
    import rcs_pkg::*;
#(
    parameter int IW    = 4,
    localparam int SW   = $clog2(IW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [IW-1:0]     rd_idx,
    input  logic              halted,
    input  logic              len_err_set,
    output logic [IW-1:0]     base,
    output logic [IW-1:0]     mask,
    output logic [IW-1:0]     wr_idx,
    output logic              halt_req,
    output logic [CNT_W-1:0]  max_len
);
    logic [SW-1:0] size_lg;
    logic [IW-1:0] cmpl_idx, wr_new, delta, room;
    logic          ovf_hit, err_len, err_ovf;
    logic          wr_sel;

    // Derive the index mask and the overflow verdict for a write-index update.
    always_comb begin
        mask    = ~({IW{1'b1}} << size_lg);
        wr_new  = reg_wdata[IW-1:0] & mask;
        delta   = (wr_new - wr_idx) & mask;
        room    = (cmpl_idx - wr_idx - IW'(1)) & mask;
        ovf_hit = delta > room;
        wr_sel  = reg_we && (reg_addr == REG_WR);
    end

    // Register writes, overflow rejection and sticky error bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0; size_lg <= SW'(IW); wr_idx <= '0; cmpl_idx <= '0;
            halt_req <= 1'b0; max_len <= '1; err_len <= 1'b0; err_ovf <= 1'b0;
        end else begin
            err_len <= err_len | len_err_set;
            if (wr_sel) begin
                if (ovf_hit) err_ovf <= 1'b1;
                else         wr_idx  <= wr_new;
            end
            if (reg_we) begin
                case (reg_addr)
                    REG_BASE: base     <= reg_wdata[IW-1:0];
                    REG_SIZE: size_lg  <= (reg_wdata > 32'(IW)) ? SW'(IW) : reg_wdata[SW-1:0];
                    REG_CMPL: cmpl_idx <= reg_wdata[IW-1:0] & mask;
                    REG_CMD:  halt_req <= reg_wdata[0];
                    REG_MAX:  max_len  <= reg_wdata[CNT_W-1:0];
                    REG_ERR: begin
                        err_len <= (err_len & ~reg_wdata[0]) | len_err_set;
                        err_ovf <= err_ovf & ~reg_wdata[1];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Read-back multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_BASE: reg_rdata[IW-1:0]    = base;
            REG_SIZE: reg_rdata[SW-1:0]    = size_lg;
            REG_WR:   reg_rdata[IW-1:0]    = wr_idx;
            REG_RD:   reg_rdata[IW-1:0]    = rd_idx;
            REG_CMPL: reg_rdata[IW-1:0]    = cmpl_idx;
            REG_CMD:  reg_rdata[3:0]       = {halted, 2'b00, halt_req};
            REG_MAX:  reg_rdata[CNT_W-1:0] = max_len;
            REG_ERR:  reg_rdata[1:0]       = {err_ovf, err_len};
            default:  reg_rdata = '0;
        endcase
    end

    // R7
    ovf_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && ovf_hit) |=> ($stable(wr_idx) && err_ovf));
endmodule

// File: rtl/rcs_fetch_fsm.sv
// Fetch engine: reads the descriptor at the read index, applies the length
// cap, offers it on the request port, tracks gather chains and honours halt
// only at chain boundaries. Assumes one descriptor in flight at a time.
module rcs_fetch_fsm
    import rcs_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IW-1:0]     base,
    input  logic [IW-1:0]     mask,
    input  logic [IW-1:0]     wr_idx,
    input  logic              halt_req,
    input  logic [CNT_W-1:0]  max_len,
    output logic              mem_re,
    output logic [IW-1:0]     mem_raddr,
    input  desc_t             mem_rdata,
    output logic [IW-1:0]     rd_idx,
    output logic              halted,
    output logic              len_err_set,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [BUF_AW-1:0] req_addr,
    output logic [CNT_W-1:0]  req_len,
    output logic              req_swap,
    output logic [TAG_W-1:0]  req_tag,
    output logic              req_first,
    output logic              req_last,
    output logic              copy_done
);
    eng_state_e    state;
    logic          in_chain;
    logic          stop_now;
    logic [IW-1:0] rd_next;

    // Fetch decision and memory addressing for the current read index.
    always_comb begin
        stop_now  = halt_req && !in_chain;
        rd_next   = (rd_idx + IW'(1)) & mask;
        mem_raddr = base + rd_idx;
        mem_re    = (state == ENG_IDLE) && !stop_now && (rd_idx != wr_idx);
        halted    = (state == ENG_HALT);
    end

    // Engine sequencing: idle, load descriptor, offer it, or hold halted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ENG_IDLE; rd_idx <= '0; in_chain <= 1'b0;
            req_valid <= 1'b0; req_addr <= '0; req_len <= '0; req_swap <= 1'b0;
            req_tag <= '0; req_first <= 1'b0; req_last <= 1'b0;
            copy_done <= 1'b0; len_err_set <= 1'b0;
        end else begin
            copy_done   <= 1'b0;
            len_err_set <= 1'b0;
            case (state)
                ENG_IDLE: begin
                    if (stop_now)                state <= ENG_HALT;
                    else if (rd_idx != wr_idx)   state <= ENG_LOAD;
                end
                ENG_LOAD: begin
                    req_addr  <= mem_rdata.addr;
                    req_len   <= mem_rdata.nbytes;
                    req_swap  <= mem_rdata.flags[1];
                    req_tag   <= mem_rdata.flags[15:TAG_LSB];
                    req_first <= !in_chain;
                    req_last  <= !mem_rdata.flags[0];
                    if (mem_rdata.nbytes > max_len) begin
                        len_err_set <= 1'b1;
                        rd_idx      <= rd_next;
                        in_chain    <= mem_rdata.flags[0];
                        copy_done   <= !mem_rdata.flags[0];
                        state       <= ENG_IDLE;
                    end else begin
                        req_valid <= 1'b1;
                        state     <= ENG_SEND;
                    end
                end
                ENG_SEND: begin
                    if (req_ready) begin
                        req_valid <= 1'b0;
                        rd_idx    <= rd_next;
                        in_chain  <= !req_last;
                        copy_done <= req_last;
                        state     <= ENG_IDLE;
                    end
                end
                ENG_HALT: begin
                    if (!halt_req) state <= ENG_IDLE;
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len)));
    // R4
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_idx) |-> (rd_idx == (($past(rd_idx) + IW'(1)) & $past(mask))));
    // R8
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !req_valid);
    // R6
    len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len <= max_len));
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        copy_done |=> !copy_done);
endmodule

// File: rtl/ring_copy_src.sv
// Top of the descriptor-ring source engine: joins the register file, the
// descriptor memory and the fetch engine. Assumes DESC_DEPTH is a power of 2.
module ring_copy_src
    import rcs_pkg::*;
#(
    parameter int DESC_DEPTH = 16,
    localparam int IW        = $clog2(DESC_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              desc_we,
    input  logic [IW-1:0]     desc_waddr,
    input  logic [63:0]       desc_wdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [BUF_AW-1:0] req_addr,
    output logic [CNT_W-1:0]  req_len,
    output logic              req_swap,
    output logic [TAG_W-1:0]  req_tag,
    output logic              req_first,
    output logic              req_last,
    output logic              copy_done
);
    logic [IW-1:0]    base, mask, wr_idx, rd_idx, mem_raddr;
    logic             halt_req, halted, len_err_set, mem_re;
    logic [CNT_W-1:0] max_len;
    desc_t            mem_rdata;

    rcs_ctrl_regs #(.IW(IW)) u_regs (
        .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .rd_idx, .halted, .len_err_set,
        .base, .mask, .wr_idx, .halt_req, .max_len
    );

    rcs_desc_ram #(.DEPTH(DESC_DEPTH)) u_ram (
        .clk, .we(desc_we), .waddr(desc_waddr), .wdata(desc_t'(desc_wdata)),
        .re(mem_re), .raddr(mem_raddr), .rdata(mem_rdata)
    );

    rcs_fetch_fsm #(.IW(IW)) u_fsm (
        .clk, .rst_n, .base, .mask, .wr_idx, .halt_req, .max_len,
        .mem_re, .mem_raddr, .mem_rdata, .rd_idx, .halted, .len_err_set,
        .req_valid, .req_ready, .req_addr, .req_len, .req_swap, .req_tag,
        .req_first, .req_last, .copy_done
    );
endmodule

// File: tb/ring_copy_src_bench.sv
module ring_copy_src_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int IW         = 4;
    localparam int NVEC       = 7;
    localparam logic [15:0] CAP = 16'h0800;
    localparam logic [3:0] BASE = 4'd12;
    // descriptor vectors: {flags, byte count, address}
    localparam logic [63:0] VEC [NVEC] = '{
        {16'h0000, 16'h0040, 32'h1000_0000},
        {16'h0001, 16'h0800, 32'h2000_0100},
        {16'h0003, 16'h0010, 32'h2000_0900},
        {16'h0008, 16'h0020, 32'h2000_1000},
        {16'h0000, 16'h0900, 32'h3000_0000},
        {16'hFFF8, 16'h0004, 32'h4000_0000},
        {16'h0002, 16'h0001, 32'h5000_0000}
    };

    logic clk = 0, rst_n = 0;
    logic reg_we = 0, desc_we = 0, req_ready = 0;
    logic [3:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic [IW-1:0] desc_waddr = 0;
    logic [63:0] desc_wdata = 0;
    logic req_valid, req_swap, req_first, req_last, copy_done;
    logic [31:0] req_addr;
    logic [15:0] req_len;
    logic [12:0] req_tag;
    int n_chk = 0, n_bad = 0, done_cnt = 0;

    ring_copy_src #(.DESC_DEPTH(DEPTH)) u_ring_copy_src (
        .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .desc_we, .desc_waddr, .desc_wdata, .req_valid, .req_ready,
        .req_addr, .req_len, .req_swap, .req_tag, .req_first, .req_last,
        .copy_done
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) if (rst_n && copy_done) done_cnt++;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic put_desc(input int slot, input logic [63:0] d);
        @(negedge clk); desc_we = 1; desc_waddr = IW'(slot); desc_wdata = d;
        @(negedge clk); desc_we = 0;
    endtask

    task automatic wait_valid();
        for (int k = 0; k < 50 && !req_valid; k++) @(negedge clk);
    endtask

    task automatic accept();
        req_ready = 1; @(negedge clk); req_ready = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        logic prev_g;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11 valid after reset", req_valid, 0);
        reg_rd(4'd3, rv); chk("R11 read index after reset", rv, 0);
        reg_rd(4'd2, rv); chk("R11 write index after reset", rv, 0);
        reg_rd(4'd5, rv); chk("R11 halted after reset", rv[3], 0);
        reg_rd(4'd7, rv); chk("R11 errors after reset", rv, 0);
        reg_rd(4'd1, rv); chk("R3 size after reset", rv, IW);

        // R3 eight-entry ring placed at base slot 12 (wraps the memory)
        reg_wr(4'd1, 3);
        reg_wr(4'd0, BASE);
        reg_wr(4'd6, CAP);
        for (int i = 0; i < NVEC; i++) put_desc((BASE + i) % DEPTH, VEC[i]);
        @(negedge clk);
        chk("R4 no fetch while indices equal", req_valid, 0);
        reg_wr(4'd2, NVEC);

        prev_g = 0;
        for (int i = 0; i < NVEC; i++) begin
            logic [15:0] fl, ln;
            fl = VEC[i][63:48]; ln = VEC[i][47:32];
            if (ln <= CAP) begin
                wait_valid();
                chk("R1 address", req_addr, VEC[i][31:0]);
                chk("R1 byte count", req_len, ln);
                chk("R1 swap", req_swap, fl[1]);
                chk("R1 tag", req_tag, fl[15:3]);
                chk("R2 first", req_first, !prev_g);
                chk("R2 last", req_last, !fl[0]);
                repeat (2) @(negedge clk);
                chk("R5 valid held", req_valid, 1);
                chk("R5 address held", req_addr, VEC[i][31:0]);
                accept();
            end
            prev_g = fl[0];
        end
        repeat (6) @(negedge clk);
        chk("R6 nothing more offered", req_valid, 0);
        reg_rd(4'd3, rv); chk("R4 read index after ring", rv, NVEC);
        reg_rd(4'd7, rv); chk("R6 length error bit", rv[0], 1);
        chk("R10 completion pulses", done_cnt, 5);

        // R7 completion index 0, write index 7: advancing to 0 must be refused
        reg_wr(4'd2, 0);
        reg_rd(4'd7, rv); chk("R7 overflow bit", rv[1], 1);
        reg_rd(4'd2, rv); chk("R7 write index kept", rv, 7);
        repeat (4) @(negedge clk);
        chk("R7 refused write fetches nothing", req_valid, 0);
        reg_wr(4'd7, 3);
        reg_rd(4'd7, rv); chk("R11 errors cleared", rv, 0);

        // R8 halt while idle
        reg_wr(4'd5, 1);
        repeat (2) @(negedge clk);
        reg_rd(4'd5, rv); chk("R8 halted status", rv[3], 1);
        reg_wr(4'd4, 7);
        put_desc((BASE + 7) % DEPTH, {16'h0001, 16'h0008, 32'h6000_0000});
        put_desc(BASE, {16'h0000, 16'h000C, 32'h6000_0100});
        reg_wr(4'd2, 1);
        repeat (5) @(negedge clk);
        chk("R8 no request while halted", req_valid, 0);
        reg_rd(4'd3, rv); chk("R8 read index frozen", rv, 7);

        // R9 resume, then request halt in the middle of a chain
        reg_wr(4'd5, 0);
        wait_valid();
        chk("R9 chain head address", req_addr, 32'h6000_0000);
        reg_wr(4'd5, 1);
        accept();
        wait_valid();
        chk("R9 chain tail still offered", req_addr, 32'h6000_0100);
        chk("R9 chain tail last", req_last, 1);
        accept();
        repeat (2) @(negedge clk);
        reg_rd(4'd5, rv); chk("R9 halted after chain", rv[3], 1);
        reg_rd(4'd3, rv); chk("R9 read index after chain", rv, 1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule